// File: doc/BRIEF.md
# Chainable Synchronous Up-Counter

This block is a binary up-counter built from identical 4-bit slices. Every slice changes only on the rising clock edge. Each slice can be cleared to zero, loaded with a parallel value, advanced by one, or held. Clear wins over load, and load wins over counting.

A slice counts only when both of its enables are high: a local enable and a chain enable. Each slice produces a carry flag. The flag is high when the slice holds all ones and its chain enable is high; the local enable has no part in it.

The top module joins the slices into one wider counter. The carry of each slice drives the chain enable of the next slice. The local enable, clear and load are shared by all slices. With the default of two slices the result is an 8-bit counter that wraps from 255 to 0. The carry of the last slice can in turn chain a further counter.

Top module: `sync_cascade_counter`

## Requirements
- R1: Clear, load and counting take effect only at a rising clock edge. Driving clear low between edges leaves the count unchanged until the next edge.
- R2: With `clr_n` low at an edge, the count becomes zero. This holds whatever the load and enable inputs are.
- R3: With `clr_n` high and `load_n` low at an edge, the count takes the value of `load_val`. This holds whatever the enables are.
- R4: With `clr_n` and `load_n` both high, and `count_en` and `chain_en` both 1 at an edge, the full-width count increases by one.
- R5: Counting from the all-ones value gives zero. Each 4-bit slice steps from 1111 to 0000, and the default 8-bit counter steps from 255 to 0.
- R6: With `clr_n` and `load_n` both high and either enable at 0, the count keeps its value.
- R7: `carry_out` is 1 exactly when `chain_en` is 1 and every count bit is 1. It follows `chain_en` within the same cycle, and `count_en` has no effect on it.
- R8: A slice other than the lowest advances only on an edge where every slice below it holds all ones. Bits 7..4 of the default counter change on a count edge only when bits 3..0 are 1111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| count_en | input | 1 | Local count enable, shared by all slices |
| chain_en | input | 1 | Chain enable into the lowest slice; also gates `carry_out` |
| load_val | input | STAGES*STAGE_W (8) | Parallel load value |
| count | output | STAGES*STAGE_W (8) | Current count |
| carry_out | output | 1 | Carry flag of the highest slice, for chaining |

## Verification
Several controls can be active at the same edge, so the order of priority has to be tested directly. The bench asserts clear together with load and both enables, and then load together with both enables. It judges the result by which of the three candidate next values appears at `count` after the edge. The ripple from the low slice into the high one is provoked at 0x0F→0x10 and at 0xFF→0x00. A full 256-step sweep then compares every value and the carry flag against a model counter held in the bench.

// File: rtl/cnt_slice.sv
`timescale 1ns/1ps
module cnt_slice #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         cnt_en,
  input  logic         chain_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         carry
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!clr_n)                q <= '0;
    else if (!load_n)          q <= din;
    else if (cnt_en && chain_en) q <= q + 1'b1;
  end

  assign carry = chain_en & (q == ALL_ONES);

  logic armed = 1'b0;
  always_ff @(posedge clk) if (!clr_n) armed <= 1'b1;

  // R2
  clear_wins_chk: assert property (@(posedge clk) disable iff (!armed)
    !clr_n |=> q == '0);
  // R3
  load_over_count_chk: assert property (@(posedge clk) disable iff (!armed)
    clr_n && !load_n |=> q == $past(din));
  // R4
  step_chk: assert property (@(posedge clk) disable iff (!armed)
    clr_n && load_n && cnt_en && chain_en && q != ALL_ONES |=> q == $past(q) + 1'b1);
  // R5
  slice_wrap_chk: assert property (@(posedge clk) disable iff (!armed)
    clr_n && load_n && cnt_en && carry |=> q == '0);
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!armed)
    clr_n && load_n && !(cnt_en && chain_en) |=> $stable(q));
  // R7
  carry_gate_chk: assert property (@(posedge clk) disable iff (!armed)
    !chain_en |-> !carry);
endmodule

// File: rtl/sync_cascade_counter.sv
`timescale 1ns/1ps
module sync_cascade_counter #(
  parameter int STAGES  = 2,
  parameter int STAGE_W = 4
) (
  input  logic                       clk,
  input  logic                       clr_n,
  input  logic                       load_n,
  input  logic                       count_en,
  input  logic                       chain_en,
  input  logic [STAGES*STAGE_W-1:0]  load_val,
  output logic [STAGES*STAGE_W-1:0]  count,
  output logic                       carry_out
);
  localparam int TW = STAGES * STAGE_W;

  logic [STAGES:0] link;
  assign link[0] = chain_en;

  for (genvar k = 0; k < STAGES; k++) begin : g_slice
    cnt_slice #(.W(STAGE_W)) u_slice (
      .clk      (clk),
      .clr_n    (clr_n),
      .load_n   (load_n),
      .cnt_en   (count_en),
      .chain_en (link[k]),
      .din      (load_val[k*STAGE_W +: STAGE_W]),
      .q        (count[k*STAGE_W +: STAGE_W]),
      .carry    (link[k+1])
    );
  end

  assign carry_out = link[STAGES];

  logic armed = 1'b0;
  always_ff @(posedge clk) if (!clr_n) armed <= 1'b1;

  // R5
  full_wrap_chk: assert property (@(posedge clk) disable iff (!armed)
    clr_n && load_n && count_en && carry_out |=> count == '0);
  // R8
  upper_hold_chk: assert property (@(posedge clk) disable iff (!armed)
    clr_n && load_n && !link[1] |=> count[TW-1:STAGE_W] == $past(count[TW-1:STAGE_W]));
  // R4
  full_step_chk: assert property (@(posedge clk) disable iff (!armed)
    clr_n && load_n && count_en && chain_en && !carry_out |=> count == $past(count) + 1'b1);
endmodule

// File: tb/sync_cascade_counter_test.sv
`timescale 1ns/1ps
module sync_cascade_counter_test;
  logic       clk = 1'b0;
  logic       clr_n = 1'b0, load_n = 1'b1, count_en = 1'b0, chain_en = 1'b0;
  logic [7:0] load_val = 8'h00;
  logic [7:0] count;
  logic       carry_out;
  int         applied = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;

  sync_cascade_counter uut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .count_en(count_en),
    .chain_en(chain_en), .load_val(load_val), .count(count), .carry_out(carry_out)
  );

  // {req, clr_n, load_n, count_en, chain_en, load_val, exp_count, exp_carry}
  localparam int NV = 19;
  localparam logic [24:0] VEC [NV] = '{
    {4'd2, 4'b0111, 8'h00, 8'h00, 1'b0},  // R2 clear beats counting
    {4'd2, 4'b0011, 8'hA5, 8'h00, 1'b0},  // R2 clear beats load
    {4'd3, 4'b1011, 8'hA5, 8'hA5, 1'b0},  // R3 load beats counting
    {4'd4, 4'b1111, 8'h00, 8'hA6, 1'b0},  // R4 step
    {4'd6, 4'b1101, 8'h00, 8'hA6, 1'b0},  // R6 local enable low
    {4'd6, 4'b1110, 8'h00, 8'hA6, 1'b0},  // R6 chain enable low
    {4'd3, 4'b1011, 8'h0E, 8'h0E, 1'b0},  // R3
    {4'd7, 4'b1111, 8'h00, 8'h0F, 1'b0},  // R7 low slice full, top not
    {4'd8, 4'b1111, 8'h00, 8'h10, 1'b0},  // R8 ripple into upper slice
    {4'd4, 4'b1111, 8'h00, 8'h11, 1'b0},  // R4
    {4'd3, 4'b1000, 8'hFE, 8'hFE, 1'b0},  // R3 load with enables low
    {4'd7, 4'b1111, 8'h00, 8'hFF, 1'b1},  // R7 carry at all ones
    {4'd7, 4'b1101, 8'h00, 8'hFF, 1'b1},  // R7 local enable has no effect
    {4'd7, 4'b1100, 8'h00, 8'hFF, 1'b0},  // R7 chain enable gates carry
    {4'd5, 4'b1111, 8'h00, 8'h00, 1'b0},  // R5 255 -> 0
    {4'd3, 4'b1000, 8'hF0, 8'hF0, 1'b0},  // R3
    {4'd8, 4'b1111, 8'h00, 8'hF1, 1'b0},  // R8 upper stays
    {4'd3, 4'b1000, 8'h3F, 8'h3F, 1'b0},  // R3
    {4'd8, 4'b1111, 8'h00, 8'h40, 1'b0}   // R8
  };

  task automatic check(input string req, input logic [7:0] q_exp, input logic c_exp);
    applied++;
    if (count !== q_exp || carry_out !== c_exp) begin
      errors++;
      $display("FAIL %s: count=%h carry=%b expected count=%h carry=%b",
               req, count, carry_out, q_exp, c_exp);
    end
  endtask

  task automatic step(input logic c, input logic l, input logic pe, input logic te,
                      input logic [7:0] d);
    @(negedge clk);
    clr_n = c; load_n = l; count_en = pe; chain_en = te; load_val = d;
    @(posedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] model;
    // reset state: clear held at first edge (R2)
    @(posedge clk); #1;
    check("R2", 8'h00, 1'b0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16:9]);
      check($sformatf("R%0d", VEC[i][24:21]), VEC[i][8:1], VEC[i][0]);
    end

    // R1: clear driven between edges has no effect until the edge
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h5A);
    check("R1", 8'h5A, 1'b0);
    @(negedge clk);
    clr_n = 1'b0; load_n = 1'b1;
    #1;
    check("R1", 8'h5A, 1'b0);
    @(posedge clk); #1;
    check("R1", 8'h00, 1'b0);

    // R5 / R8 / R7: full sweep against a model counter
    step(1'b1, 1'b0, 1'b0, 1'b1, 8'h00);
    model = 8'h00;
    for (int n = 0; n < 257; n++) begin
      step(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
      model = model + 8'h01;
      check("R5", model, model == 8'hFF);
    end

    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end
endmodule